// File: doc/BRIEF.md
# Load-Store-Queue Access Predictor

This block sits beside the load path of a core and decides, when a load is fetched, whether the data cache needs to be probed for it. It keeps a small learned table, indexed by the low bits of the load PC. Each entry holds a few dependency slots. A slot gives a distance in queue entries, counted backwards from the queue slot the load is allocated to, to an older memory operation that supplied the load's data through store-to-load forwarding. If every recorded producer is still resident in the load-store queue when the load is fetched, the load is marked queue-only and the cache enable for it stays low. Otherwise the cache is enabled as usual.

The decision is taken at fetch, so the cache and the queue are never probed in parallel just in case. At execute the core reports what forwarding actually did. The table learns the observed source distance, or forgets the entry when the load needed the cache. If a queue-only prediction turns out wrong, the block raises a replay request so the load goes to the cache, and clears the entry so the same load does not mispredict again. A recovery flush drops a prediction that is being made in the same cycle.

Top module: `lsq_fwd_filter`

## Requirements
- R1: After reset, pred_valid and replay_req are 0, and every table entry is empty, so the first fetch of any PC predicts a cache access (pred_lsq_only=0, dcache_en=1).
- R2: A fetch at a clock edge with flush low gives pred_valid=1 after that edge, with exactly one of pred_lsq_only and dcache_en high. With no fetch, both are 0.
- R3: If the entry selected by fetch_pc[7:2] has at least one valid slot and the producer of every valid slot is resident (its lsq_valid bit is 1), the prediction is queue-only: pred_lsq_only=1 and dcache_en=0.
- R4: If any valid slot's producer is not resident, or the entry has no valid slot, the prediction enables the cache.
- R5: The producer of a slot with distance d is queue entry (fetch_lsq_idx - d) mod QDEPTH, so distances wrap around the circular queue.
- R6: An execute report with exec_src_valid=1 and a nonzero exec_src_dist inserts that distance into the entry for exec_pc. A distance already present is not duplicated. A new distance takes the lowest free slot, and when all NDEP slots are full it replaces the highest slot.
- R7: An execute report with exec_pred_lsq_only=1 and exec_fwd_full=0 sets replay_req to 1 after that edge and empties the entry for exec_pc.
- R8: An execute report that is not a misprediction and has exec_src_valid=0 empties the entry for exec_pc.
- R9: flush high at a fetch edge suppresses that prediction: pred_valid, pred_lsq_only and dcache_en are 0 after the edge.
- R10: An execute report with exec_src_valid=1 and exec_src_dist=0 leaves the entry unchanged.
- R11: A fetch and an execute report for the same entry in the same cycle predict from the entry's contents before that report is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | A load is fetched this cycle |
| fetch_pc | input | PCW | PC of the fetched load |
| fetch_lsq_idx | input | log2(QDEPTH) | Queue slot allocated to the fetched load |
| lsq_valid | input | QDEPTH | Per-slot residency of the load-store queue |
| flush | input | 1 | Misprediction recovery; drops this cycle's prediction |
| exec_valid | input | 1 | An execute report is present |
| exec_pc | input | PCW | PC of the executing load |
| exec_pred_lsq_only | input | 1 | The load was predicted queue-only |
| exec_fwd_full | input | 1 | Forwarding supplied all of the load's data |
| exec_src_valid | input | 1 | A forwarding source was observed |
| exec_src_dist | input | log2(QDEPTH) | Distance in queue slots to that source |
| pred_valid | output | 1 | A prediction is presented |
| pred_lsq_only | output | 1 | The load takes its data from the queue only |
| dcache_en | output | 1 | Data cache access enabled for the predicted load |
| replay_req | output | 1 | Replay the load through the data cache |

## Verification
The hardest case to reach from the ports is a queue-only prediction whose producers sit across the wrap of the circular queue while the entry is also full. That needs two trainings of distinct distances, a third that overwrites, and then a fetch whose allocated slot is smaller than the distance. The directed part builds exactly this sequence. The random part draws PCs from a pool of four that share entries, so that trainings, clears and predictions collide on the same entries, often in the same cycle.

// File: rtl/lsqp_pkg.sv
// Package: shared types for the load-store-queue access predictor.
// Assumes nothing beyond the parameters of the modules that import it.
package lsqp_pkg;
    // What an execute report does to the table entry of its load.
    typedef enum logic [1:0] {
        TR_NONE   = 2'd0,
        TR_CLEAR  = 2'd1,
        TR_INSERT = 2'd2
    } train_act_e;
endpackage

// File: rtl/lsqp_dep_table.sv
// Module: dependency table with two combinational read ports and one write port.
// Each entry holds NDEP slots, each a valid bit and a distance.
// Assumes TBL_DEPTH is a power of two. Reset clears only the valid bits.
module lsqp_dep_table #(
    parameter int TBL_DEPTH = 64,
    parameter int NDEP      = 2,
    parameter int QIW       = 4,
    localparam int TIW      = $clog2(TBL_DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TIW-1:0]           rd_a_idx,
    output logic [NDEP-1:0]          rd_a_vld,
    output logic [NDEP-1:0][QIW-1:0] rd_a_dist,
    input  logic [TIW-1:0]           rd_b_idx,
    output logic [NDEP-1:0]          rd_b_vld,
    output logic [NDEP-1:0][QIW-1:0] rd_b_dist,
    input  logic                     wr_en,
    input  logic [TIW-1:0]           wr_idx,
    input  logic [NDEP-1:0]          wr_vld,
    input  logic [NDEP-1:0][QIW-1:0] wr_dist
);
    logic [NDEP-1:0]          vld_q  [TBL_DEPTH];
    logic [NDEP-1:0][QIW-1:0] dist_q [TBL_DEPTH];

    // Read ports: the contents before any write at the coming edge.
    assign rd_a_vld  = vld_q[rd_a_idx];
    assign rd_a_dist = dist_q[rd_a_idx];
    assign rd_b_vld  = vld_q[rd_b_idx];
    assign rd_b_dist = dist_q[rd_b_idx];

    // Valid bits: cleared at reset, then updated by the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TBL_DEPTH; i++) vld_q[i] <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_vld;
        end
    end

    // Distances: plain storage, only meaningful where the valid bit is set.
    always_ff @(posedge clk) begin
        if (wr_en) dist_q[wr_idx] <= wr_dist;
    end
endmodule

// File: rtl/lsqp_resident_chk.sv
// Module: decides whether every recorded producer of a load is still resident.
// Producer slot = (base_idx - distance) mod QDEPTH. Assumes QDEPTH is a power of two.
module lsqp_resident_chk #(
    parameter int QDEPTH = 16,
    parameter int NDEP   = 2,
    localparam int QIW   = $clog2(QDEPTH)
) (
    input  logic [NDEP-1:0]          slot_vld,
    input  logic [NDEP-1:0][QIW-1:0] slot_dist,
    input  logic [QIW-1:0]           base_idx,
    input  logic [QDEPTH-1:0]        lsq_valid,
    output logic                     lsq_only
);
    logic [NDEP-1:0] slot_ok;

    // One residency test per slot; an unused slot never blocks.
    for (genvar g = 0; g < NDEP; g++) begin : g_slot
        logic [QIW-1:0] prod_idx;
        assign prod_idx   = base_idx - slot_dist[g];
        assign slot_ok[g] = !slot_vld[g] || lsq_valid[prod_idx];
    end

    // Queue-only needs at least one recorded producer and all of them resident.
    assign lsq_only = (|slot_vld) && (&slot_ok);
endmodule

// File: rtl/lsqp_trainer.sv
// Module: turns an execute report into the new contents of its table entry.
// Assumes cur_vld/cur_dist are the entry for the executing load before update.
module lsqp_trainer
    import lsqp_pkg::*;
#(
    parameter int NDEP = 2,
    parameter int QIW  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exec_valid,
    input  logic                     exec_pred_lsq_only,
    input  logic                     exec_fwd_full,
    input  logic                     exec_src_valid,
    input  logic [QIW-1:0]           exec_src_dist,
    input  logic [NDEP-1:0]          cur_vld,
    input  logic [NDEP-1:0][QIW-1:0] cur_dist,
    output logic                     mispred,
    output logic                     wr_en,
    output logic [NDEP-1:0]          wr_vld,
    output logic [NDEP-1:0][QIW-1:0] wr_dist
);
    train_act_e      act;
    logic            hit;
    logic            has_free;
    logic [NDEP-1:0] pick;

    // Classify the report: misprediction, new source, or no source.
    always_comb begin
        mispred = exec_valid && exec_pred_lsq_only && !exec_fwd_full;
        act     = TR_NONE;
        if (exec_valid) begin
            if (mispred)                     act = TR_CLEAR;
            else if (!exec_src_valid)        act = TR_CLEAR;
            else if (exec_src_dist != '0)    act = TR_INSERT;
        end
    end

    // Find a duplicate distance and the lowest free slot.
    always_comb begin
        hit      = 1'b0;
        has_free = 1'b0;
        pick     = '0;
        for (int i = 0; i < NDEP; i++) begin
            if (cur_vld[i] && cur_dist[i] == exec_src_dist) hit = 1'b1;
        end
        for (int i = NDEP - 1; i >= 0; i--) begin
            if (!cur_vld[i]) begin
                has_free = 1'b1;
                pick     = '0;
                pick[i]  = 1'b1;
            end
        end
        if (!has_free) pick[NDEP-1] = 1'b1;
    end

    // Build the entry to write back.
    always_comb begin
        wr_en   = (act != TR_NONE);
        wr_vld  = cur_vld;
        wr_dist = cur_dist;
        if (act == TR_CLEAR) begin
            wr_vld = '0;
        end else if (act == TR_INSERT && !hit) begin
            for (int i = 0; i < NDEP; i++) begin
                if (pick[i]) begin
                    wr_vld[i]  = 1'b1;
                    wr_dist[i] = exec_src_dist;
                end
            end
        end
    end

    // A written slot that is valid never points at the load itself.
    for (genvar g = 0; g < NDEP; g++) begin : g_chk
        p_nozero_dist_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_vld[g]) |-> (wr_dist[g] != '0));
    end
endmodule

// File: rtl/lsq_fwd_filter.sv
// Module: top of the load-store-queue access predictor.
// Predicts at fetch whether a load can skip the data cache, from a PC-indexed
// table of producer distances, and learns from execute reports.
// Assumes QDEPTH and TBL_DEPTH are powers of two and loads are 4-byte aligned.
module lsq_fwd_filter #(
    parameter int PCW       = 32,
    parameter int QDEPTH    = 16,
    parameter int TBL_DEPTH = 64,
    parameter int NDEP      = 2,
    localparam int QIW      = $clog2(QDEPTH),
    localparam int TIW      = $clog2(TBL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PCW-1:0]    fetch_pc,
    input  logic [QIW-1:0]    fetch_lsq_idx,
    input  logic [QDEPTH-1:0] lsq_valid,
    input  logic              flush,
    input  logic              exec_valid,
    input  logic [PCW-1:0]    exec_pc,
    input  logic              exec_pred_lsq_only,
    input  logic              exec_fwd_full,
    input  logic              exec_src_valid,
    input  logic [QIW-1:0]    exec_src_dist,
    output logic              pred_valid,
    output logic              pred_lsq_only,
    output logic              dcache_en,
    output logic              replay_req
);
    logic [TIW-1:0]           fetch_tidx;
    logic [TIW-1:0]           exec_tidx;
    logic [NDEP-1:0]          fa_vld;
    logic [NDEP-1:0][QIW-1:0] fa_dist;
    logic [NDEP-1:0]          ex_vld;
    logic [NDEP-1:0][QIW-1:0] ex_dist;
    logic                     tr_wr_en;
    logic [NDEP-1:0]          tr_vld;
    logic [NDEP-1:0][QIW-1:0] tr_dist;
    logic                     tr_mispred;
    logic                     chk_lsq_only;

    assign fetch_tidx = fetch_pc[TIW+1:2];
    assign exec_tidx  = exec_pc[TIW+1:2];

    lsqp_dep_table #(.TBL_DEPTH(TBL_DEPTH), .NDEP(NDEP), .QIW(QIW)) u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(fetch_tidx), .rd_a_vld(fa_vld), .rd_a_dist(fa_dist),
        .rd_b_idx(exec_tidx),  .rd_b_vld(ex_vld), .rd_b_dist(ex_dist),
        .wr_en(tr_wr_en), .wr_idx(exec_tidx), .wr_vld(tr_vld), .wr_dist(tr_dist)
    );

    lsqp_resident_chk #(.QDEPTH(QDEPTH), .NDEP(NDEP)) u_chk (
        .slot_vld(fa_vld), .slot_dist(fa_dist), .base_idx(fetch_lsq_idx),
        .lsq_valid(lsq_valid), .lsq_only(chk_lsq_only)
    );

    lsqp_trainer #(.NDEP(NDEP), .QIW(QIW)) u_trn (
        .clk(clk), .rst_n(rst_n),
        .exec_valid(exec_valid), .exec_pred_lsq_only(exec_pred_lsq_only),
        .exec_fwd_full(exec_fwd_full), .exec_src_valid(exec_src_valid),
        .exec_src_dist(exec_src_dist), .cur_vld(ex_vld), .cur_dist(ex_dist),
        .mispred(tr_mispred), .wr_en(tr_wr_en), .wr_vld(tr_vld), .wr_dist(tr_dist)
    );

    // Register the fetch prediction and the replay request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_valid    <= 1'b0;
            pred_lsq_only <= 1'b0;
            replay_req    <= 1'b0;
        end else begin
            pred_valid    <= fetch_valid && !flush;
            pred_lsq_only <= fetch_valid && !flush && chk_lsq_only;
            replay_req    <= tr_mispred;
        end
    end

    // Cache is enabled for every presented prediction that is not queue-only.
    assign dcache_en = pred_valid && !pred_lsq_only;

    p_fetch_pred_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(fetch_valid) && !$past(flush)) |-> pred_valid);

    p_flush_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flush)) |-> (!pred_valid && !dcache_en));

    p_replay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(exec_valid) && $past(exec_pred_lsq_only)
         && !$past(exec_fwd_full)) |-> replay_req);

    p_one_choice_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> $countones({pred_lsq_only, dcache_en}) == 1);
endmodule

// File: tb/lsq_fwd_filter_tb_top.sv
`timescale 1ns/1ps
module lsq_fwd_filter_tb_top;
    localparam int PCW = 32, QDEPTH = 16, TBL = 64, NDEP = 2, QIW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fetch_valid = 0, flush = 0, exec_valid = 0;
    logic exec_pred_lsq_only = 0, exec_fwd_full = 0, exec_src_valid = 0;
    logic [PCW-1:0] fetch_pc = '0, exec_pc = '0;
    logic [QIW-1:0] fetch_lsq_idx = '0, exec_src_dist = '0;
    logic [QDEPTH-1:0] lsq_valid = '0;
    logic pred_valid, pred_lsq_only, dcache_en, replay_req;

    int checks = 0, errors = 0;
    bit m_vld [TBL][NDEP];
    int m_dist[TBL][NDEP];
    bit e_pv, e_lo, e_rp;

    always #4 clk = ~clk;

    lsq_fwd_filter #(.PCW(PCW), .QDEPTH(QDEPTH), .TBL_DEPTH(TBL), .NDEP(NDEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .fetch_lsq_idx(fetch_lsq_idx), .lsq_valid(lsq_valid), .flush(flush),
        .exec_valid(exec_valid), .exec_pc(exec_pc), .exec_pred_lsq_only(exec_pred_lsq_only),
        .exec_fwd_full(exec_fwd_full), .exec_src_valid(exec_src_valid),
        .exec_src_dist(exec_src_dist), .pred_valid(pred_valid),
        .pred_lsq_only(pred_lsq_only), .dcache_en(dcache_en), .replay_req(replay_req)
    );

    function automatic int tidx(logic [PCW-1:0] pc);
        return int'(pc[7:2]);
    endfunction

    // Expected queue-only decision from the model (R3, R4, R5).
    function automatic bit exp_lsq_only(int t, int base, logic [QDEPTH-1:0] lv);
        bit any = 0, ok = 1;
        for (int i = 0; i < NDEP; i++) begin
            if (m_vld[t][i]) begin
                any = 1;
                if (!lv[(base - m_dist[t][i] + QDEPTH) % QDEPTH]) ok = 0;
            end
        end
        return any && ok;
    endfunction

    // Apply an execute report to the model (R6, R7, R8, R10).
    task automatic model_train();
        int t = tidx(exec_pc);
        bit hit = 0;
        int fr = -1;
        if (!exec_valid) return;
        if (exec_pred_lsq_only && !exec_fwd_full || !exec_src_valid) begin
            for (int i = 0; i < NDEP; i++) m_vld[t][i] = 0;
        end else if (exec_src_dist != 0) begin
            for (int i = 0; i < NDEP; i++)
                if (m_vld[t][i] && m_dist[t][i] == int'(exec_src_dist)) hit = 1;
            for (int i = NDEP - 1; i >= 0; i--) if (!m_vld[t][i]) fr = i;
            if (!hit) begin
                if (fr < 0) fr = NDEP - 1;
                m_vld[t][fr] = 1;
                m_dist[t][fr] = int'(exec_src_dist);
            end
        end
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One cycle: compute expectations, clock, update model, then compare.
    task automatic cycle(string req);
        e_pv = fetch_valid && !flush;
        e_lo = e_pv && exp_lsq_only(tidx(fetch_pc), int'(fetch_lsq_idx), lsq_valid);
        e_rp = exec_valid && exec_pred_lsq_only && !exec_fwd_full;
        @(posedge clk);
        model_train();
        @(negedge clk);
        check(req, "pred_valid", int'(pred_valid), int'(e_pv));
        check(req, "pred_lsq_only", int'(pred_lsq_only), int'(e_lo));
        check(req, "dcache_en", int'(dcache_en), int'(e_pv && !e_lo));
        check(req, "replay_req", int'(replay_req), int'(e_rp));
    endtask

    task automatic idle();
        fetch_valid = 0; flush = 0; exec_valid = 0;
        exec_pred_lsq_only = 0; exec_fwd_full = 0; exec_src_valid = 0;
    endtask

    task automatic fetch(logic [PCW-1:0] pc, int idx, logic [QDEPTH-1:0] lv);
        fetch_valid = 1; fetch_pc = pc; fetch_lsq_idx = QIW'(idx); lsq_valid = lv;
    endtask

    task automatic train(logic [PCW-1:0] pc, bit plo, bit full, bit sv, int d);
        exec_valid = 1; exec_pc = pc; exec_pred_lsq_only = plo;
        exec_fwd_full = full; exec_src_valid = sv; exec_src_dist = QIW'(d);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int seed;
        logic [PCW-1:0] pool [4];
        seed = 7;
        void'($urandom(seed));
        pool[0] = 32'h100; pool[1] = 32'h104; pool[2] = 32'h200; pool[3] = 32'h108;
        for (int t = 0; t < TBL; t++)
            for (int i = 0; i < NDEP; i++) begin m_vld[t][i] = 0; m_dist[t][i] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state
        check("R1", "pred_valid after reset", int'(pred_valid), 0);
        check("R1", "replay_req after reset", int'(replay_req), 0);
        fetch(32'h100, 5, '1); cycle("R1");
        check("R1", "empty entry enables cache", int'(dcache_en), 1);

        // R6, R3, R5: train distance 3, producer slot 2 resident
        idle(); train(32'h100, 0, 1, 1, 3); cycle("R6");
        idle(); fetch(32'h100, 5, 16'h0004); cycle("R3");
        check("R3", "queue-only", int'(pred_lsq_only), 1);
        // R4: producer gone
        idle(); fetch(32'h100, 5, 16'hfffb); cycle("R4");
        check("R4", "cache on missing producer", int'(dcache_en), 1);
        // R5: wrap, idx 1 dist 3 -> slot 14
        idle(); fetch(32'h100, 1, 16'h4000); cycle("R5");
        check("R5", "wrapped producer", int'(pred_lsq_only), 1);
        // R6: duplicate, second, overwrite on full
        idle(); train(32'h100, 0, 1, 1, 3); cycle("R6");
        idle(); train(32'h100, 0, 1, 1, 6); cycle("R6");
        idle(); train(32'h100, 0, 1, 1, 9); cycle("R6");
        idle(); fetch(32'h100, 1, 16'h4000 | 16'h0100); cycle("R6");
        check("R6", "slots 3 and 9 resident", int'(pred_lsq_only), 1);
        // R10: distance 0 ignored
        idle(); train(32'h100, 0, 1, 1, 0); cycle("R10");
        idle(); fetch(32'h100, 1, 16'h4100); cycle("R10");
        check("R10", "entry unchanged", int'(pred_lsq_only), 1);
        // R11: fetch and clear in same cycle see old contents
        idle(); fetch(32'h100, 1, 16'h4100); train(32'h100, 0, 1, 0, 0); cycle("R11");
        check("R11", "old contents used", int'(pred_lsq_only), 1);
        // R8: entry now cleared
        idle(); fetch(32'h100, 1, '1); cycle("R8");
        check("R8", "cleared entry", int'(dcache_en), 1);
        // R7: misprediction replays and clears
        idle(); train(32'h104, 0, 1, 1, 2); cycle("R7");
        idle(); train(32'h104, 1, 0, 1, 2); cycle("R7");
        check("R7", "replay", int'(replay_req), 1);
        idle(); fetch(32'h104, 8, '1); cycle("R7");
        check("R7", "cleared after mispredict", int'(pred_lsq_only), 0);
        // R9: flush drops prediction
        idle(); train(32'h104, 0, 1, 1, 2); cycle("R9");
        idle(); fetch(32'h104, 8, '1); flush = 1; cycle("R9");
        check("R9", "flushed", int'(pred_valid), 0);

        // Random phase across all requirements (R2 one-hot choice)
        for (int n = 0; n < 3000; n++) begin
            idle();
            if ($urandom_range(3) != 0)
                fetch(pool[$urandom_range(3)], $urandom_range(15), QDEPTH'($urandom));
            flush = ($urandom_range(15) == 0);
            if ($urandom_range(1) == 1)
                train(pool[$urandom_range(3)], 1'($urandom_range(1)),
                      1'($urandom_range(3) != 0), 1'($urandom_range(4) != 0),
                      $urandom_range(15));
            cycle("R2");
        end
        idle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule